// File: doc/BRIEF.md
# Vectored Exception Dispatch Controller

This block sits beside a processor's fetch unit and decides when normal program flow is interrupted. Six request lines come in: system reset, machine check, alignment, floating-point, external interrupt and decrementer. When one or more are active and allowed, the block accepts the one with the highest fixed priority. In the same clock edge it saves the program counter and part of the machine state register, switches the machine state to a safe supervisor setting, and issues a one-cycle redirect to that exception's handler. The handler address is computed, not looked up. Each vector owns 0x100 bytes. The table sits either at address zero or at 0xFFF00000, as an MSR prefix bit selects.

A return-from-interrupt strobe reverses the entry. It reloads the restorable MSR bits from the second save register and redirects fetch to the address held in the first, with its two low bits forced to zero. The decoder can also load the whole MSR through a write port. Decrementer counting, instruction decode and memory are outside this block.

Bit positions below use plain index numbering, where bit 0 is the least significant. Within the MSR, bit 16 is the interrupt-little-endian copy (ILE), bit 15 is the external enable (EE) and bit 14 is the user/supervisor flag (PR). Bit 6 picks the table prefix (IP), bit 1 is the recoverable flag (RI) and bit 0 is the little-endian mode (LE). The restorable set is the mask 0x0000FF73.

Top module: `exc_dispatch`

## Requirements
- R1: While rst_n is low and after it rises, MSR equals 0x00000040 (prefix bit 6 set), both save registers are zero, and redir_valid is 0.
- R2: An accepted exception redirects to base + vector×0x100. The base is 0 when MSR bit 6 is 0 and 0xFFF00000 when it is 1. The vector numbers are system reset 1, machine check 2, external 5, alignment 6, floating-point 7 and decrementer 9. redir_vec carries the vector number.
- R3: When several requests are active at once, the winner follows this order: system reset first, then machine check, then alignment, then floating-point, then external, then decrementer.
- R4: External and decrementer requests are ignored while MSR bit 15 is 0. System reset and machine check are accepted regardless of MSR.
- R5: On entry, MSR bits 15, 14 and 1 become 0 and bit 0 takes the old bit 16. Every other bit is kept, so a nested entry saves bit 1 as 0.
- R6: On entry, SRR1 receives the old MSR ANDed with 0x0000FF73.
- R7: On entry, SRR0 receives cur_pc for alignment and floating-point requests, and cur_pc + 4 for all other requests.
- R8: Return from interrupt loads the MSR bits in mask 0x0000FF73 from SRR1 and keeps the rest. It redirects to SRR0 with bits 1:0 cleared, and redir_vec is 0.
- R9: redir_valid rises one clock after the accepting edge and lasts one cycle. In the same cycle an exception overrides return-from-interrupt, and return-from-interrupt overrides an MSR write.
- R10: With msr_we high and no exception or return, the MSR is loaded with msr_wdata on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_sreset | input | 1 | System reset exception request |
| req_mcheck | input | 1 | Machine check request |
| req_align | input | 1 | Alignment exception request (synchronous) |
| req_fpu | input | 1 | Floating-point exception request (synchronous) |
| req_ext | input | 1 | External interrupt request (maskable) |
| req_dec | input | 1 | Decrementer interrupt request (maskable) |
| cur_pc | input | 32 | Address of the instruction at the exception point |
| rfi | input | 1 | Return-from-interrupt strobe |
| msr_we | input | 1 | MSR write enable from the decoder |
| msr_wdata | input | 32 | MSR write data |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_pc | output | 32 | Redirect target address |
| redir_vec | output | 5 | Vector number of the redirect (0 for a return) |
| msr | output | 32 | Machine state register |
| srr0 | output | 32 | Saved program counter |
| srr1 | output | 32 | Saved machine state |

## Verification
A wrong MSR bit shows at the msr port on the clock after the entry, return or write that caused it. If the error is in EE or IP, it also shows at the next masked request or redirect, because an interrupt is then taken or missed, or the target lands in the wrong table. A wrong save register shows at srr0 or srr1 at once. It also comes back one return later, as a wrong redirect address or a wrong restored MSR, so the bench carries every value through at least one entry and return pair. A priority or vector error shows as a wrong redir_pc or redir_vec on the single redirect cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int NREQ      = 6;
  localparam int VW        = 5;
  localparam int IDXW      = $clog2(NREQ);
  localparam int VEC_SHIFT = 8;

  // MSR bit positions (index 0 = least significant)
  localparam int B_ILE = 16;
  localparam int B_EE  = 15;
  localparam int B_PR  = 14;
  localparam int B_IP  = 6;
  localparam int B_RI  = 1;
  localparam int B_LE  = 0;

  localparam logic [XLEN-1:0] RESTORE_MASK = 32'h0000_FF73;
  localparam logic [XLEN-1:0] HIGH_BASE    = 32'hFFF0_0000;

  // request index order is the priority order (0 = highest)
  typedef enum logic [IDXW-1:0] {
    SRC_SRESET = 3'd0,
    SRC_MCHECK = 3'd1,
    SRC_ALIGN  = 3'd2,
    SRC_FPU    = 3'd3,
    SRC_EXT    = 3'd4,
    SRC_DEC    = 3'd5
  } src_e;

  localparam logic [NREQ-1:0] MASKABLE = 6'b11_0000;

  function automatic logic [VW-1:0] vec_of(input src_e s);
    case (s)
      SRC_SRESET: vec_of = 5'd1;
      SRC_MCHECK: vec_of = 5'd2;
      SRC_EXT:    vec_of = 5'd5;
      SRC_ALIGN:  vec_of = 5'd6;
      SRC_FPU:    vec_of = 5'd7;
      default:    vec_of = 5'd9;
    endcase
  endfunction

  function automatic logic is_sync(input src_e s);
    is_sync = (s == SRC_ALIGN) || (s == SRC_FPU);
  endfunction

  function automatic logic [XLEN-1:0] handler_addr(input logic ip, input logic [VW-1:0] v);
    logic [XLEN-1:0] off;
    off = {{(XLEN-VW){1'b0}}, v} << VEC_SHIFT;
    handler_addr = (ip ? HIGH_BASE : '0) | off;
  endfunction

  function automatic logic [XLEN-1:0] entry_msr(input logic [XLEN-1:0] m);
    logic [XLEN-1:0] r;
    r       = m;
    r[B_EE] = 1'b0;
    r[B_PR] = 1'b0;
    r[B_RI] = 1'b0;
    r[B_LE] = m[B_ILE];
    entry_msr = r;
  endfunction

  function automatic logic [XLEN-1:0] restore_msr(input logic [XLEN-1:0] m,
                                                  input logic [XLEN-1:0] saved);
    restore_msr = (m & ~RESTORE_MASK) | (saved & RESTORE_MASK);
  endfunction

  function automatic logic [XLEN-1:0] return_pc(input logic [XLEN-1:0] s0);
    return_pc = {s0[XLEN-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
#(
  parameter int N = NREQ,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] maskable,
  input  logic         enable,
  output logic [N-1:0] grant,
  output logic [W-1:0] idx,
  output logic         any
);
  logic [N-1:0] eff;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_eff
      assign eff[g] = req[g] & (enable | ~maskable[g]);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eff[i]) idx = W'(i);
    end
  end

  assign any   = |eff;
  assign grant = any ? (N'(1) << idx) : '0;

  always_comb begin
    a_r3_grant_onehot: assert ($onehot0(grant));
    if (any) a_r4_grant_allowed: assert ((grant & req) != '0);
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] MSR_RST = 32'h0000_0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  src_e            take_src,
  input  logic            rfi_do,
  input  logic            msr_we,
  input  logic [XLEN-1:0] msr_wdata,
  input  logic [XLEN-1:0] cur_pc,
  output logic [XLEN-1:0] msr_q,
  output logic [XLEN-1:0] srr0_q,
  output logic [XLEN-1:0] srr1_q
);
  logic [XLEN-1:0] saved_pc;
  assign saved_pc = is_sync(take_src) ? cur_pc : cur_pc + XLEN'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q  <= MSR_RST;
      srr0_q <= '0;
      srr1_q <= '0;
    end else if (take) begin
      srr0_q <= saved_pc;
      srr1_q <= msr_q & RESTORE_MASK;
      msr_q  <= entry_msr(msr_q);
    end else if (rfi_do) begin
      msr_q  <= restore_msr(msr_q, srr1_q);
    end else if (msr_we) begin
      msr_q  <= msr_wdata;
    end
  end

  a_r5_entry_safe: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!msr_q[B_EE] && !msr_q[B_PR] && !msr_q[B_RI]));
  a_r6_srr1_saved: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (srr1_q == ($past(msr_q) & RESTORE_MASK)));
  a_r7_sync_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (take_src == SRC_ALIGN || take_src == SRC_FPU)) |=> (srr0_q == $past(cur_pc)));
  a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_do |=> ((msr_q & RESTORE_MASK) == ($past(srr1_q) & RESTORE_MASK)));
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  src_e            take_src,
  input  logic            rfi_do,
  input  logic            table_high,
  input  logic [XLEN-1:0] srr0_q,
  output logic            valid_q,
  output logic [XLEN-1:0] pc_q,
  output logic [VW-1:0]   vec_q
);
  logic [VW-1:0] vec_w;
  assign vec_w = vec_of(take_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      vec_q   <= '0;
    end else begin
      valid_q <= take | rfi_do;
      if (take) begin
        pc_q  <= handler_addr(table_high, vec_w);
        vec_q <= vec_w;
      end else if (rfi_do) begin
        pc_q  <= return_pc(srr0_q);
        vec_q <= '0;
      end
    end
  end

  a_r2_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc_q[VEC_SHIFT-1:0] == '0));
  a_r8_return_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_do |=> (pc_q == {$past(srr0_q[XLEN-1:2]), 2'b00}));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter logic [31:0] MSR_RST = 32'h0000_0040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_sreset,
  input  logic        req_mcheck,
  input  logic        req_align,
  input  logic        req_fpu,
  input  logic        req_ext,
  input  logic        req_dec,
  input  logic [31:0] cur_pc,
  input  logic        rfi,
  input  logic        msr_we,
  input  logic [31:0] msr_wdata,
  output logic        redir_valid,
  output logic [31:0] redir_pc,
  output logic [4:0]  redir_vec,
  output logic [31:0] msr,
  output logic [31:0] srr0,
  output logic [31:0] srr1
);
  logic [NREQ-1:0] req_vec;
  logic [NREQ-1:0] grant_w;
  logic [IDXW-1:0] idx_w;
  logic            take_w;
  logic            rfi_do_w;
  logic            ee_w;
  src_e            src_w;

  assign req_vec  = {req_dec, req_ext, req_fpu, req_align, req_mcheck, req_sreset};
  assign ee_w     = msr[B_EE];
  assign src_w    = src_e'(idx_w);
  assign rfi_do_w = rfi & ~take_w;

  exc_prio #(.N(NREQ)) u_prio (
    .req      (req_vec),
    .maskable (MASKABLE),
    .enable   (ee_w),
    .grant    (grant_w),
    .idx      (idx_w),
    .any      (take_w)
  );

  exc_regs #(.MSR_RST(MSR_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_w),
    .take_src  (src_w),
    .rfi_do    (rfi_do_w),
    .msr_we    (msr_we),
    .msr_wdata (msr_wdata),
    .cur_pc    (cur_pc),
    .msr_q     (msr),
    .srr0_q    (srr0),
    .srr1_q    (srr1)
  );

  exc_redirect u_redir (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take_w),
    .take_src   (src_w),
    .rfi_do     (rfi_do_w),
    .table_high (msr[B_IP]),
    .srr0_q     (srr0),
    .valid_q    (redir_valid),
    .pc_q       (redir_pc),
    .vec_q      (redir_vec)
  );

  a_r4_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_w && !req_sreset && !req_mcheck && !req_align && !req_fpu) |-> !take_w);
  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req_sreset |-> (take_w && grant_w[0]));
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w || rfi) |=> redir_valid);
  a_r9_exc_over_rfi: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && rfi) |=> (redir_vec != 5'd0));
endmodule

// File: tb/exc_dispatch_tb.sv
module exc_dispatch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_sreset = 0, req_mcheck = 0, req_align = 0, req_fpu = 0, req_ext = 0, req_dec = 0;
  logic [31:0] cur_pc = '0;
  logic rfi = 0, msr_we = 0;
  logic [31:0] msr_wdata = '0;
  logic redir_valid;
  logic [31:0] redir_pc, msr, srr0, srr1;
  logic [4:0] redir_vec;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_dispatch u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_sreset(req_sreset), .req_mcheck(req_mcheck), .req_align(req_align),
    .req_fpu(req_fpu), .req_ext(req_ext), .req_dec(req_dec),
    .cur_pc(cur_pc), .rfi(rfi), .msr_we(msr_we), .msr_wdata(msr_wdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_vec(redir_vec),
    .msr(msr), .srr0(srr0), .srr1(srr1)
  );

  // behavioural reference model
  logic [31:0] m_msr, m_srr0, m_srr1, m_pc;
  logic        m_v;
  logic [4:0]  m_vec;
  localparam logic [31:0] KEEP = 32'h0000_FF73;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_msr = 32'h40; m_srr0 = 0; m_srr1 = 0; m_v = 0; m_pc = 0; m_vec = 0;
    end else begin
      int who;
      int vec;
      who = -1;
      if (req_sreset) who = 0;
      else if (req_mcheck) who = 1;
      else if (req_align) who = 2;
      else if (req_fpu) who = 3;
      else if (req_ext && m_msr[15]) who = 4;
      else if (req_dec && m_msr[15]) who = 5;
      m_v = 0;
      if (who >= 0) begin
        case (who)
          0: vec = 1; 1: vec = 2; 2: vec = 6; 3: vec = 7; 4: vec = 5; default: vec = 9;
        endcase
        m_srr1 = m_msr & KEEP;
        m_srr0 = (who == 2 || who == 3) ? cur_pc : cur_pc + 4;
        m_pc   = (m_msr[6] ? 32'hFFF0_0000 : 32'h0) + vec * 256;
        m_vec  = 5'(vec);
        m_msr[0] = m_msr[16];
        m_msr[1] = 0; m_msr[14] = 0; m_msr[15] = 0;
        m_v = 1;
      end else if (rfi) begin
        m_pc  = m_srr0 & ~32'h3;
        m_vec = 0;
        m_msr = (m_msr & ~KEEP) | (m_srr1 & KEEP);
        m_v = 1;
      end else if (msr_we) begin
        m_msr = msr_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("model redir_valid R9", {31'b0, redir_valid}, {31'b0, m_v});
      chk("model redir_pc R2", redir_pc, m_pc);
      chk("model redir_vec R2", {27'b0, redir_vec}, {27'b0, m_vec});
      chk("model msr R5", msr, m_msr);
      chk("model srr0 R7", srr0, m_srr0);
      chk("model srr1 R6", srr1, m_srr1);
    end
  end

  task automatic clr();
    {req_sreset, req_mcheck, req_align, req_fpu, req_ext, req_dec, rfi, msr_we} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    clr();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <5000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 msr", msr, 32'h40);
    chk("R1 srr0", srr0, 0);
    chk("R1 srr1", srr1, 0);
    chk("R1 valid", {31'b0, redir_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4: external ignored with EE=0
    req_ext = 1; cur_pc = 32'h100; step();
    chk("R4 masked valid", {31'b0, redir_valid}, 0);
    chk("R4 masked msr", msr, 32'h40);

    // R10: MSR write
    msr_we = 1; msr_wdata = 32'h0001_C032; step();
    chk("R10 msr write", msr, 32'h0001_C032);

    // R3/R5/R6/R7: fpu beats ext and dec
    req_ext = 1; req_dec = 1; req_fpu = 1; cur_pc = 32'h1000; step();
    chk("R3 fpu wins pc", redir_pc, 32'h700);
    chk("R2 vec", {27'b0, redir_vec}, 7);
    chk("R7 sync srr0", srr0, 32'h1000);
    chk("R6 srr1", srr1, 32'h0000_C032);
    chk("R5 entry msr", msr, 32'h0001_0031);
    step();
    chk("R9 single cycle", {31'b0, redir_valid}, 0);

    // R8 return
    rfi = 1; step();
    chk("R8 return pc", redir_pc, 32'h1000);
    chk("R8 restored msr", msr, 32'h0001_C032);
    step();

    // R3 ext beats dec, R7 async saves next
    req_ext = 1; req_dec = 1; cur_pc = 32'h2000; step();
    chk("R3 ext wins", redir_pc, 32'h500);
    chk("R7 async srr0", srr0, 32'h2004);

    // R9 exception over rfi, R5 nested RI=0 saved
    rfi = 1; req_mcheck = 1; cur_pc = 32'h3000; step();
    chk("R9 mcheck over rfi", redir_pc, 32'h200);
    chk("R5 nested srr1", srr1, 32'h31);
    step();

    // R2 high table
    msr_we = 1; msr_wdata = 32'h8040; step();
    req_dec = 1; cur_pc = 32'h5000; step();
    chk("R2 high dec", redir_pc, 32'hFFF0_0900);
    chk("R2 dec srr0", srr0, 32'h5004);

    // R3/R4 reset beats mcheck with EE=0
    req_sreset = 1; req_mcheck = 1; cur_pc = 32'h6000; step();
    chk("R3 sreset wins", redir_pc, 32'hFFF0_0100);
    chk("R4 nonmaskable srr1", srr1, 32'h40);

    // R7 sync with odd pc, R8 low bits cleared
    req_align = 1; cur_pc = 32'h4003; step();
    chk("R7 align srr0", srr0, 32'h4003);
    chk("R2 align pc", redir_pc, 32'hFFF0_0600);
    rfi = 1; step();
    chk("R8 low bits", redir_pc, 32'h4000);
    chk("R8 vec zero", {27'b0, redir_vec}, 0);

    // R9 rfi over msr write
    rfi = 1; msr_we = 1; msr_wdata = 32'hFFFF_FFFF; step();
    chk("R9 rfi over write", msr, 32'h40);

    repeat (3) step();
    finish_run();
  end
endmodule